// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block gathers interrupt requests from up to fifteen peripherals and four core sources. It turns them into a single "interrupt taken" event that carries a vector address. Each peripheral has a fixed source ID. Software writes a 4-bit priority code per ID, and that code decides which bit of the 16-bit pending and enable registers the source lands on. Priority level `p` maps to bit `p+4`. Bits 0 to 3 belong to the core sources. Every source whose level is 11 or higher shares bit 15 and its vector.

The controller picks the lowest-numbered bit that is both pending and enabled. It registers a one-cycle take pulse together with the vector, which is the bit index times 0x20. It also tracks which bits are in service. A return strobe from the core retires the highest-priority bit in service. Software reaches every register through one synchronous write/read port. Writing the pending register forces or clears pending bits directly.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the priority code of source ID `i` is `i` for IDs 0 to 10 and 11 for IDs 11 to 14. The control, enable, pending and in-service registers read as zero.
- R2: A rising edge on `src_req[i]` sets pending bit `min(code_i,11)+4`. Any code above 11 acts as 11, so all such sources share bit 15.
- R3: The winning interrupt is the lowest set bit of (pending AND enabled). Its vector on `irq_vec` equals the bit index times 0x20, for example bit 15 gives 0x01E0.
- R4: Bits 3 to 15 are maskable. Such a bit can be taken only when its enable bit (register address 1) is set and control bit 5 (global enable) is set.
- R5: Core bits 0, 1 and 2 are taken regardless of the enable register and of control bit 5. Control bit 8 blocks bit 2 (power-down) only.
- R6: While control bit 4 (nesting) is clear and any in-service bit is set, no interrupt is taken.
- R7: While nesting is set, an interrupt is taken during service only if its bit index is strictly lower than every in-service bit.
- R8: On a take, the pending bit clears and the in-service bit sets. `irq_ret` clears the lowest-indexed in-service bit.
- R9: When bit 15 is taken while any source at level 11 still holds its request high, bit 15 stays pending.
- R10: A write to address 2 replaces the pending register with the written value, which forces or clears bits. A request edge in the same cycle still sets its bit.
- R11: Register map, 3-bit address, data read one cycle after the address:
  - Address 0 is control.
  - Address 1 is enable.
  - Address 2 is pending.
  - Address 3 is in-service, read-only.
  - Addresses 4 to 7 each hold the codes of four IDs: address `4+g` holds ID `4g+k` at bits `4k+3:4k`.
  - ID 15 does not exist and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| src_req | input | 15 | Peripheral requests, bit i is source ID i |
| core_req | input | 4 | Core requests for bits 0 to 3 (0 emulation, 1 reset, 2 power-down, 3 stack) |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_take | output | 1 | One-cycle pulse when an interrupt is taken |
| irq_vec | output | 16 | Vector of the taken interrupt, held until the next take |

## Verification
The assertions assume `irq_ret` is pulsed only while some bit is in service. They also assume the priority table and control register change only through the register port, never in the middle of an expected take. The stimulus follows both assumptions. Every random iteration uses a single source pulse, waits for that source to be taken, returns, and idles before the next one. Directed cases cover the rest:
- sources that collide in the same cycle,
- preemption with a lower-priority request left waiting,
- the shared level-11 bit under a held request,
- the unmaskable core bits and the power-down block.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_MASK  = 3'd1,
    RA_PEND  = 3'd2,
    RA_INSV  = 3'd3
  } reg_addr_e;

  localparam int CTL_NEST  = 4;
  localparam int CTL_GIE   = 5;
  localparam int CTL_PDBLK = 8;
endpackage

// File: rtl/irq_prio_table.sv
module irq_prio_table #(
  parameter int NUM_SRC   = 15,
  parameter int PRIO_W    = 4,
  parameter int DATA_W    = 16,
  parameter int TOP_LEVEL = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_grp,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  localparam int PER_GRP = DATA_W / PRIO_W;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int GRP  = i / PER_GRP;
    localparam int SLOT = i % PER_GRP;
    localparam int RSTV = (i < TOP_LEVEL) ? i : TOP_LEVEL;
    always_ff @(posedge clk) begin
      if (rst)
        prio_flat[i*PRIO_W +: PRIO_W] <= PRIO_W'(RSTV);
      else if (wr_en && wr_grp == 2'(GRP))
        prio_flat[i*PRIO_W +: PRIO_W] <= wr_data[SLOT*PRIO_W +: PRIO_W];
    end
  end
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map #(
  parameter int NUM_SRC   = 15,
  parameter int PRIO_W    = 4,
  parameter int BITS      = 16,
  parameter int CORE_BITS = 4,
  parameter int TOP_LEVEL = 11
) (
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [NUM_SRC-1:0]        src_edge,
  input  logic [NUM_SRC-1:0]        src_lvl,
  output logic [BITS-1:0]           set_bits,
  output logic                      top_hold
);
  localparam int IDX_W = $clog2(BITS);

  always_comb begin
    set_bits = '0;
    top_hold = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      logic [PRIO_W-1:0] code;
      logic [PRIO_W-1:0] lvl;
      logic [IDX_W-1:0]  pos;
      code = prio_flat[i*PRIO_W +: PRIO_W];
      lvl  = (code > PRIO_W'(TOP_LEVEL)) ? PRIO_W'(TOP_LEVEL) : code;
      pos  = IDX_W'(lvl) + IDX_W'(CORE_BITS);
      set_bits[pos] = set_bits[pos] | src_edge[i];
      if (lvl == PRIO_W'(TOP_LEVEL))
        top_hold = top_hold | src_lvl[i];
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int W = 16
) (
  input  logic [W-1:0]         vec,
  output logic                 found,
  output logic [$clog2(W)-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int b = W - 1; b >= 0; b--) begin
      if (vec[b]) begin
        found = 1'b1;
        idx   = $clog2(W)'(b);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int            NUM_SRC   = 15,
  parameter int            PRIO_W    = 4,
  parameter int            BITS      = 16,
  parameter int            CORE_BITS = 4,
  parameter int            TOP_LEVEL = 11,
  parameter int            VEC_SHIFT = 5,
  parameter int            VEC_W     = 16,
  parameter logic [3:0]    NMI_SET   = 4'b0111,
  parameter int            PD_BIT    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [BITS-1:0]      reg_wdata,
  output logic [BITS-1:0]      reg_rdata,
  input  logic [NUM_SRC-1:0]   src_req,
  input  logic [CORE_BITS-1:0] core_req,
  input  logic                 irq_ret,
  output logic                 irq_take,
  output logic [VEC_W-1:0]     irq_vec
);
  import irq_pkg::*;
  localparam int IDX_W = $clog2(BITS);
  localparam int TOP_BIT = TOP_LEVEL + CORE_BITS;

  logic [BITS-1:0] ctrl_q, mask_q, pend_q, insv_q, pend_d, insv_d, en_bits, set_bits;
  logic [NUM_SRC-1:0] src_q;
  logic [CORE_BITS-1:0] core_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [4*BITS-1:0] prio_pad;
  logic top_hold, cand_found, insv_found, take_ok;
  logic [IDX_W-1:0] cand_idx, insv_idx;

  irq_prio_table #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(BITS), .TOP_LEVEL(TOP_LEVEL)) u_tab (
    .clk(clk), .rst(rst), .wr_en(reg_we && reg_addr[2]), .wr_grp(reg_addr[1:0]),
    .wr_data(reg_wdata), .prio_flat(prio_flat));

  irq_src_map #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .BITS(BITS), .CORE_BITS(CORE_BITS),
                .TOP_LEVEL(TOP_LEVEL)) u_map (
    .prio_flat(prio_flat), .src_edge(src_req & ~src_q), .src_lvl(src_req),
    .set_bits(set_bits), .top_hold(top_hold));

  // Enable per bit: unmaskable core bits bypass mask and global enable
  for (genvar b = 0; b < BITS; b++) begin : g_en
    if (b < CORE_BITS && NMI_SET[b % 4] && b == PD_BIT) begin : g_pd
      assign en_bits[b] = !ctrl_q[CTL_PDBLK];
    end else if (b < CORE_BITS && NMI_SET[b % 4]) begin : g_nmi
      assign en_bits[b] = 1'b1;
    end else begin : g_mk
      assign en_bits[b] = mask_q[b] & ctrl_q[CTL_GIE];
    end
  end

  irq_pick #(.W(BITS)) u_cand (.vec(pend_q & en_bits), .found(cand_found), .idx(cand_idx));
  irq_pick #(.W(BITS)) u_insv (.vec(insv_q), .found(insv_found), .idx(insv_idx));

  assign take_ok = cand_found &&
                   (!insv_found || (ctrl_q[CTL_NEST] && cand_idx < insv_idx));

  always_comb begin
    pend_d = (reg_we && reg_addr == RA_PEND) ? reg_wdata : pend_q;
    if (take_ok && !(cand_idx == IDX_W'(TOP_BIT) && top_hold))
      pend_d[cand_idx] = 1'b0;
    pend_d = pend_d | set_bits | BITS'(core_req & ~core_q);
    insv_d = insv_q;
    if (irq_ret && insv_found) insv_d[insv_idx] = 1'b0;
    if (take_ok) insv_d[cand_idx] = 1'b1;
  end

  assign prio_pad = (4*BITS)'(prio_flat);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; mask_q <= '0; pend_q <= '0; insv_q <= '0;
      src_q <= '0; core_q <= '0;
      irq_take <= 1'b0; irq_vec <= '0; reg_rdata <= '0;
    end else begin
      if (reg_we && reg_addr == RA_CTRL) ctrl_q <= reg_wdata;
      if (reg_we && reg_addr == RA_MASK) mask_q <= reg_wdata;
      pend_q   <= pend_d;
      insv_q   <= insv_d;
      src_q    <= src_req;
      core_q   <= core_req;
      irq_take <= take_ok;
      if (take_ok) irq_vec <= VEC_W'(cand_idx) << VEC_SHIFT;
      case (reg_addr)
        RA_CTRL: reg_rdata <= ctrl_q;
        RA_MASK: reg_rdata <= mask_q;
        RA_PEND: reg_rdata <= pend_q;
        RA_INSV: reg_rdata <= insv_q;
        default: reg_rdata <= prio_pad[reg_addr[1:0]*BITS +: BITS];
      endcase
    end
  end

  // Checks on taken interrupts
  logic [IDX_W-1:0] vidx;
  logic [BITS-1:0]  at_or_below;
  assign vidx = irq_vec[VEC_SHIFT +: IDX_W];
  always_comb
    for (int b = 0; b < BITS; b++) at_or_below[b] = (IDX_W'(b) <= vidx);

  a_r8_insv_marked: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> insv_q[vidx]);
  a_r6_no_nest_block: assert property (@(posedge clk) disable iff (rst)
    (insv_q != '0 && !ctrl_q[CTL_NEST]) |=> !irq_take);
  a_r7_strict_preempt: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (($past(insv_q) & at_or_below) == '0));
  a_r4_mask_gie: assert property (@(posedge clk) disable iff (rst)
    (irq_take && vidx >= IDX_W'(CORE_BITS)) |->
      ($past(ctrl_q[CTL_GIE]) && (($past(mask_q) >> vidx) & BITS'(1)) != '0));
  a_r5_pd_block: assert property (@(posedge clk) disable iff (rst)
    (irq_take && vidx == IDX_W'(PD_BIT)) |-> !$past(ctrl_q[CTL_PDBLK]));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0, irq_ret = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [14:0] src_req = '0;
  logic [3:0] core_req = '0;
  logic [15:0] reg_rdata, irq_vec;
  logic irq_take;
  int n_chk = 0, n_fail = 0;
  int codes [15];

  always #10 clk = ~clk;

  prio_irq_ctrl dut (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req), .core_req(core_req),
    .irq_ret(irq_ret), .irq_take(irq_take), .irq_vec(irq_vec));

  function automatic logic [15:0] exp_vec(int code);
    return 16'(((code > 11) ? 11 : code) + 4) * 16'h20;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #2; endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; cyc(); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a; cyc(); chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pulse_src(input logic [14:0] m);
    src_req = src_req | m; cyc(); src_req = src_req & ~m;
  endtask

  task automatic pulse_core(input logic [3:0] m);
    core_req = m; cyc(); core_req = '0;
  endtask

  task automatic ret(); irq_ret = 1'b1; cyc(); irq_ret = 1'b0; endtask

  task automatic exp_take(input logic [15:0] exp, input string tag);
    bit got = 0; logic [15:0] v = 16'hDEAD;
    for (int k = 0; k < 8 && !got; k++) begin
      cyc();
      if (irq_take) begin got = 1; v = irq_vec; end
    end
    chk(got && v == exp, tag, v, exp);
  endtask

  task automatic exp_none(input string tag);
    bit seen = 0;
    for (int k = 0; k < 6; k++) begin cyc(); if (irq_take) seen = 1; end
    chk(!seen, tag, 16'(seen), 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) cyc(); rst = 1'b0; cyc();
    // R1 / R11 reset values and register map
    rd(3'd4, 16'h3210, "R1 prio grp0"); rd(3'd5, 16'h7654, "R1 prio grp1");
    rd(3'd6, 16'hBA98, "R1 prio grp2"); rd(3'd7, 16'h0BBB, "R1 R11 prio grp3");
    rd(3'd0, 16'h0, "R1 ctrl"); rd(3'd1, 16'h0, "R1 mask");
    rd(3'd2, 16'h0, "R1 pend"); rd(3'd3, 16'h0, "R1 insv");
    // R4 mask and global enable
    pulse_src(15'h0008); exp_none("R4 masked no take");
    rd(3'd2, 16'h0080, "R2 id3 pending bit7");
    wr(3'd1, 16'hFFFF); exp_none("R4 gie off no take");
    wr(3'd0, 16'h0020); exp_take(16'h00E0, "R3 R4 take id3");
    rd(3'd2, 16'h0000, "R8 pend cleared"); rd(3'd3, 16'h0080, "R8 insv set");
    // R6 no nesting
    pulse_src(15'h0001); exp_none("R6 blocked in service");
    ret(); exp_take(16'h0080, "R6 R8 take after ret");
    rd(3'd3, 16'h0010, "R8 ret cleared bit7"); ret(); cyc();
    // R3 simultaneous sources
    pulse_src(15'h0104); exp_take(16'h00C0, "R3 higher first");
    ret(); exp_take(16'h0180, "R3 lower second"); ret(); cyc();
    // R7 nesting
    wr(3'd0, 16'h0030);
    pulse_src(15'h0040); exp_take(16'h0140, "R7 take id6");
    pulse_src(15'h0200); exp_none("R7 lower no preempt");
    pulse_src(15'h0002); exp_take(16'h00A0, "R7 preempt id1");
    rd(3'd3, 16'h0420, "R7 two in service");
    ret(); exp_none("R7 bit13 still below bit10");
    ret(); exp_take(16'h01A0, "R7 bit13 after returns"); ret(); cyc();
    rd(3'd3, 16'h0000, "R8 insv empty");
    // R9 shared top bit held
    src_req[12] = 1'b1; exp_take(16'h01E0, "R9 take bit15");
    rd(3'd2, 16'h8000, "R9 bit15 kept pending");
    src_req[12] = 1'b0; ret(); exp_take(16'h01E0, "R9 retake bit15");
    rd(3'd2, 16'h0000, "R9 bit15 cleared"); ret(); cyc();
    // R2 reprogrammed priority
    wr(3'd7, 16'h0F0B); rd(3'd7, 16'h0F0B, "R11 grp3 readback");
    pulse_src(15'h2000); exp_take(16'h0080, "R2 id13 at level0"); ret(); cyc();
    pulse_src(15'h4000); exp_take(16'h01E0, "R2 code15 aliases"); ret(); cyc();
    // R5 core bits
    wr(3'd1, 16'h0000); wr(3'd0, 16'h0000);
    pulse_core(4'b0010); exp_take(16'h0020, "R5 reset bit unmaskable"); ret(); cyc();
    pulse_core(4'b1000); exp_none("R5 stack bit maskable");
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0100); pulse_core(4'b0100); exp_none("R5 power-down blocked");
    rd(3'd2, 16'h0004, "R5 pd pending");
    wr(3'd0, 16'h0000); exp_take(16'h0040, "R5 pd after unblock"); ret(); cyc();
    // R10 force and clear
    wr(3'd1, 16'hFFFF); wr(3'd0, 16'h0020);
    wr(3'd2, 16'h0200); exp_take(16'h0120, "R10 forced bit9"); ret(); cyc();
    wr(3'd1, 16'h0000); pulse_src(15'h0020); cyc();
    wr(3'd2, 16'h0000); rd(3'd2, 16'h0000, "R10 cleared");
    wr(3'd1, 16'hFFFF); exp_none("R10 cleared no take");
    // Random priorities, one source per iteration
    for (int it = 0; it < 20; it++) begin
      for (int g = 0; g < 4; g++) begin
        logic [15:0] w = '0;
        for (int s = 0; s < 4; s++) begin
          if (g*4 + s < 15) begin
            codes[g*4+s] = int'($urandom % 16);
            w[s*4 +: 4] = 4'(codes[g*4+s]);
          end
        end
        wr(3'(4 + g), w);
      end
      begin
        int id = int'($urandom % 15);
        pulse_src(15'(1) << id);
        exp_take(exp_vec(codes[id]), "R2 R3 random mapping");
      end
      ret(); cyc(); cyc();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule